// File: doc/BRIEF.md
# Processor Reset Supervisor with Push-Button Reset

This block produces the active-low reset line of a system processor. It watches two inputs: a flag that says the processor's own supply has reached its good level, and an active-low push-button. From power-up it keeps the processor in reset. It lets go only once the supply is good and a programmable timeout has run out. A button press forces reset at once. Release then waits until the button is let go and the full timeout has run again. Release always requires the supply to still be good.

The reset line is open-drain. The block does not drive a level. It gives an enable (`rst_pull_en`): when high, the pad pulls the line low; when low, the pad lets go and an external pull-up raises it. The timeout is counted in pulses of a one-cycle strobe, nominally one per millisecond. The supply-good comparator, debouncing and synchronisation of the button, and the pull-up are outside this block, so both inputs must already be synchronous to `clk`. There is no streaming data, so every pin is a plain control or status signal.

Top module: `rst_supervisor`

## Requirements
- R1: While `clr` is high at a clock edge, the block enters its held state. `rst_pull_en` reads 1 after that edge, and a full timeout is needed before any release.
- R2: `rst_pull_en` is the only output. 1 means pull the reset line low and 0 means release it. It is never unknown after a clear.
- R3: Whenever `supply_ok` is 0, `rst_pull_en` is 1 in that same cycle, with no clock edge needed. No number of strobes releases reset while the supply is low.
- R4: Suppose `supply_ok` and `btn_n` are both 1 at edge E. Then counting starts with the next edge. Reset releases (`rst_pull_en` = 0) right after the edge that samples the TIMEOUT_TICKS-th strobe taken after E. After TIMEOUT_TICKS-1 strobes it is still 1. Idle cycles between strobes do not change this.
- R5: If `supply_ok` falls while the timeout is counting, reset stays asserted and the count is cleared. After the supply recovers, the full TIMEOUT_TICKS strobes are needed again.
- R6: `btn_n` = 0 makes `rst_pull_en` 1 in that same cycle, even when reset had been released.
- R7: While `btn_n` stays 0, reset stays asserted whatever strobes arrive. After `btn_n` returns to 1, release follows the R4 rule from that point.
- R8: A new press while the timeout is counting after an earlier press throws away the strobes already counted. The wait starts over from the later release.
- R9: A strobe has no effect unless it is sampled while counting. Strobes seen while held, and a strobe in the same cycle as the edge that starts counting, do not count toward the timeout.
- R10: If `supply_ok` falls after reset has been released, reset asserts in that same cycle. After recovery, a full timeout is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high power-on clear |
| tick_ms | input | 1 | One-cycle timeout strobe (nominally 1 ms) |
| supply_ok | input | 1 | Processor supply is at its good level |
| btn_n | input | 1 | Push-button, low while pressed |
| rst_pull_en | output | 1 | Open-drain enable: 1 pulls the reset line low |

## Verification
Assertion of reset is due in the same cycle as the input that causes it. The bench checks these one time unit after changing the input, with no clock edge in between. Release is due right after the edge that samples the final counted strobe. Each strobe is driven for exactly one cycle and the output is sampled one time unit after that edge. The edge on which the inputs first become good only arms the counter. The bench spends a separate cycle on it before counting strobes, and one case puts a strobe on that very edge to show it is not counted.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    SV_HOLD  = 2'd0,
    SV_COUNT = 2'd1,
    SV_RUN   = 2'd2
  } sv_state_e;

  function automatic int unsigned cnt_width(input int unsigned ticks);
    return (ticks > 1) ? $clog2(ticks) : 1;
  endfunction
endpackage

// File: rtl/rsv_timer.sv
module rsv_timer #(
  parameter int unsigned TIMEOUT_TICKS = 200
) (
  input  logic clk,
  input  logic clr,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = rsv_pkg::cnt_width(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr || restart) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign expire = run & tick & (cnt_q == LAST);

  // R4: the count never passes the final strobe index
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LAST);

  // R5: a restart leaves the count empty
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (clr)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm (
  input  logic clk,
  input  logic clr,
  input  logic supply_ok,
  input  logic btn_n,
  input  logic expire,
  output logic timer_run,
  output logic timer_restart,
  output logic released
);
  import rsv_pkg::*;

  sv_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!supply_ok || !btn_n) begin
      state_d = SV_HOLD;
    end else begin
      case (state_q)
        SV_HOLD:  state_d = SV_COUNT;
        SV_COUNT: if (expire) state_d = SV_RUN;
        SV_RUN:   state_d = SV_RUN;
        default:  state_d = SV_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) state_q <= SV_HOLD;
    else     state_q <= state_d;
  end

  assign timer_run     = (state_q == SV_COUNT);
  assign timer_restart = (state_q != SV_COUNT);
  assign released      = (state_q == SV_RUN);

  // R4: entry into the released state only follows an expiry
  a_r4_release_after_expiry: assert property (@(posedge clk) disable iff (clr)
    (state_q == SV_RUN && $past(state_q) != SV_RUN) |-> $past(expire));

  // R3 / R5 / R10: a low supply leaves the block held on the next edge
  a_r5_supply_drop_holds: assert property (@(posedge clk) disable iff (clr)
    !supply_ok |=> (state_q == SV_HOLD));

  // R6 / R7: a pressed button leaves the block held on the next edge
  a_r6_button_holds: assert property (@(posedge clk) disable iff (clr)
    !btn_n |=> (state_q == SV_HOLD));

  // R9: the held state never jumps straight to release
  a_r9_hold_not_to_run: assert property (@(posedge clk) disable iff (clr)
    (state_q == SV_HOLD) |=> (state_q != SV_RUN));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned TIMEOUT_TICKS = 200
) (
  input  logic clk,
  input  logic clr,
  input  logic tick_ms,
  input  logic supply_ok,
  input  logic btn_n,
  output logic rst_pull_en
);
  logic tmr_run, tmr_restart, tmr_expire, released;

  rsv_fsm fsm_i (
    .clk          (clk),
    .clr          (clr),
    .supply_ok    (supply_ok),
    .btn_n        (btn_n),
    .expire       (tmr_expire),
    .timer_run    (tmr_run),
    .timer_restart(tmr_restart),
    .released     (released)
  );

  rsv_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) timer_i (
    .clk    (clk),
    .clr    (clr),
    .restart(tmr_restart),
    .run    (tmr_run),
    .tick   (tick_ms),
    .expire (tmr_expire)
  );

  // Assertion path bypasses the state register so it is immediate.
  assign rst_pull_en = ~released | ~supply_ok | ~btn_n;

  // R2: the pad enable is always a defined level
  a_r2_known: assert property (@(posedge clk) disable iff (clr)
    !$isunknown(rst_pull_en));

  // R4: a release edge is preceded by counting, never by the held state
  a_r4_fall_needs_count: assert property (@(posedge clk) disable iff (clr)
    $fell(rst_pull_en) |-> $past(tmr_run));
endmodule

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;
  localparam int T = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic clr, tick_ms, supply_ok, btn_n;
  logic rst_pull_en;
  int n_chk = 0;
  int n_bad = 0;

  rst_supervisor #(.TIMEOUT_TICKS(T)) dut_i (
    .clk        (clk),
    .clr        (clr),
    .tick_ms    (tick_ms),
    .supply_ok  (supply_ok),
    .btn_n      (btn_n),
    .rst_pull_en(rst_pull_en)
  );

  task automatic chk(input string req, input logic exp);
    n_chk++;
    if (rst_pull_en !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_pull_en=%b expected %b", req, rst_pull_en, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    tick_ms = 1'b1;
    cyc();
    tick_ms = 1'b0;
  endtask

  // Full timeout from the counting state: T-1 strobes keep reset, the T-th frees it.
  task automatic full_wait(input string req);
    for (int i = 1; i <= T; i++) begin
      pulse();
      chk(req, (i < T) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    clr = 1'b1; tick_ms = 1'b0; supply_ok = 1'b0; btn_n = 1'b1;
    repeat (3) cyc();
    chk("R1 held after clear", 1'b1);
    clr = 1'b0;

    // R3: supply low, strobes do nothing
    for (int i = 0; i < 2 * T; i++) begin
      pulse();
      chk("R3 supply low", 1'b1);
    end

    // R4: sweep strobe counts with varying idle gaps
    for (int n = 0; n <= T + 1; n++) begin
      supply_ok = 1'b0;
      #1 chk("R3 same-cycle drop", 1'b1);
      cyc();
      supply_ok = 1'b1;
      cyc();
      for (int i = 1; i <= n; i++) begin
        repeat (i % 3) cyc();
        pulse();
        chk("R4 timeout count", (i < T) ? 1'b1 : 1'b0);
      end
      cyc();
      chk("R4 after idle", (n < T) ? 1'b1 : 1'b0);
    end

    // R9: strobe on the arming edge is not counted
    supply_ok = 1'b0;
    cyc();
    pulse();
    chk("R9 held strobe", 1'b1);
    supply_ok = 1'b1;
    tick_ms = 1'b1;
    cyc();
    tick_ms = 1'b0;
    chk("R9 arming strobe", 1'b1);
    full_wait("R9 full wait after arming strobe");

    // R1: clear from released state needs full timeout
    clr = 1'b1;
    cyc();
    chk("R1 clear from release", 1'b1);
    clr = 1'b0;
    cyc();
    full_wait("R1 timeout after clear");

    // R6 / R7: press while released
    btn_n = 1'b0;
    #1 chk("R6 immediate press", 1'b1);
    for (int i = 0; i < 2 * T; i++) begin
      pulse();
      chk("R7 button held", 1'b1);
    end
    btn_n = 1'b1;
    cyc();
    full_wait("R7 wait after release");

    // R8: second press partway through the wait
    for (int k = 1; k < T; k++) begin
      btn_n = 1'b0;
      cyc();
      btn_n = 1'b1;
      cyc();
      for (int i = 0; i < k; i++) begin
        pulse();
        chk("R8 partial wait", 1'b1);
      end
      btn_n = 1'b0;
      #1 chk("R6 press during count", 1'b1);
      cyc();
      btn_n = 1'b1;
      cyc();
      full_wait("R8 restarted wait");
    end

    // R5: supply dip partway through counting
    for (int k = 0; k < T; k++) begin
      supply_ok = 1'b0;
      cyc();
      supply_ok = 1'b1;
      cyc();
      for (int i = 0; i < k; i++) pulse();
      supply_ok = 1'b0;
      #1 chk("R5 dip during count", 1'b1);
      cyc();
      supply_ok = 1'b1;
      cyc();
      full_wait("R5 full wait after dip");
    end

    // R10: supply drop after release
    supply_ok = 1'b0;
    #1 chk("R10 drop after release", 1'b1);
    cyc();
    chk("R10 still held", 1'b1);
    supply_ok = 1'b1;
    cyc();
    full_wait("R10 wait after recovery");
    repeat (4) cyc();
    chk("R2 stays released", 1'b0);

    finish_run();
  end
endmodule